// File: doc/BRIEF.md
# Raster Event Selector

This block drives a single auxiliary raster output. A static 3-bit selection code decides what the output shows. It can show one of the timing strobes produced by a raster generator (line start, field start, frame start, tri-level sync marker). It can show a swap-qualified fetch window, or a swap-frame indication that is high for the whole first frame after a buffer swap request. It can also be held at a constant level.

A buffer-swap request pulse is remembered as pending. At the next frame start the pending request arms that frame and the pending state is cleared. The armed state lasts until the following frame start. The armed state drives the swap-frame indication directly. It also gates the fetch-window level.

Every source passes through one output register, so the output follows its source with exactly one clock of latency. Swap tracking runs all the time, whatever code is selected. The timing generator itself is outside the block.

Top module: `raster_evt_sel`

## Requirements
- R1: While `rst` is high on a clock edge, `aux_out` is low in the following cycle, and the pending and armed swap state is cleared.
- R2: Codes 1, 2, 3 and 4 select `line_start`, `field_start`, `frame_start` and `tri_sync` respectively. With such a code held, `aux_out` equals the selected strobe as sampled on the previous clock edge.
- R3: Code 6 holds `aux_out` high and code 7 holds it low. In both cases every event, window and swap input has no effect on the output.
- R4: A `swap_req` pulse sets a pending state. On the next clock edge at which `frame_start` is high, the armed state takes the pending value and the pending state is cleared. The armed state changes on no other edge.
- R5: Code 0 shows the armed state. With code 0 held, `aux_out` is high from the cycle after an arming `frame_start` through the cycle of the next `frame_start` edge, and `aux_out` changes only in the cycle after a `frame_start` edge.
- R6: A `swap_req` sampled on the same edge as `frame_start` arms the frame that starts on that edge.
- R7: Code 5 shows `fetch_win` AND the armed state (both as they stand after that edge), with one clock of latency.
- R8: Several `swap_req` pulses within one frame arm only the single next frame. The frame after that is unarmed unless a new request arrives.
- R9: Swap tracking continues while codes other than 0 and 5 are selected. A request made under code 1 is visible after a later switch to code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Static source selection code |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| field_start | input | 1 | One-cycle strobe at the start of each field |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| tri_sync | input | 1 | Tri-level sync marker strobe |
| fetch_win | input | 1 | Level, high while pixel data may be fetched |
| swap_req | input | 1 | One-cycle buffer swap request |
| aux_out | output | 1 | Registered auxiliary output |

## Verification
The assertions check several things on every cycle. They check the one-clock copy of each strobe under codes 1 to 4 and the constant levels under codes 6 and 7. They check that the qualified window is never high without the window having been high. They check that the swap-frame output moves only right after a frame start. They also check the low output after reset.

Some behaviour spans several frames and can only be shown by the bench scenarios and its cycle model. This covers the pending-to-armed hand-over and a request that coincides with a frame start. It covers collapsing several requests into one armed frame, and swap tracking carried across a change of code.

// File: rtl/raster_evt_pkg.sv
package raster_evt_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_SWAP_FRAME = 3'd0,
    SRC_LINE       = 3'd1,
    SRC_FIELD      = 3'd2,
    SRC_FRAME      = 3'd3,
    SRC_TRI        = 3'd4,
    SRC_FETCH_Q    = 3'd5,
    SRC_ONE        = 3'd6,
    SRC_ZERO       = 3'd7
  } src_sel_e;

  typedef struct packed {
    logic line_s;
    logic field_s;
    logic frame_s;
    logic tri_s;
    logic fetch_q;
    logic swap_frame;
  } evt_bus_t;
endpackage

// File: rtl/swap_tracker.sv
module swap_tracker (
  input  logic clk,
  input  logic rst,
  input  logic swap_req,
  input  logic frame_start,
  output logic armed_nxt
);
  logic pending_q;
  logic armed_q;

  // value the armed state takes on this edge, made visible now so the
  // registered output keeps a single clock of latency
  always_comb begin
    armed_nxt = armed_q;
    if (frame_start) armed_nxt = pending_q | swap_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      armed_q <= armed_nxt;
      if (frame_start) pending_q <= 1'b0;
      else if (swap_req) pending_q <= 1'b1;
    end
  end
endmodule

// File: rtl/evt_mux.sv
module evt_mux
  import raster_evt_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  evt_bus_t         evt,
  output logic             src
);
  always_comb begin
    case (src_sel_e'(sel))
      SRC_SWAP_FRAME: src = evt.swap_frame;
      SRC_LINE:       src = evt.line_s;
      SRC_FIELD:      src = evt.field_s;
      SRC_FRAME:      src = evt.frame_s;
      SRC_TRI:        src = evt.tri_s;
      SRC_FETCH_Q:    src = evt.fetch_q;
      SRC_ONE:        src = 1'b1;
      default:        src = 1'b0;
    endcase
  end
endmodule

// File: rtl/raster_evt_sel.sv
module raster_evt_sel
  import raster_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             line_start,
  input  logic             field_start,
  input  logic             frame_start,
  input  logic             tri_sync,
  input  logic             fetch_win,
  input  logic             swap_req,
  output logic             aux_out
);
  logic     armed_nxt;
  logic     src;
  evt_bus_t evt;

  swap_tracker u_swap (
    .clk         (clk),
    .rst         (rst),
    .swap_req    (swap_req),
    .frame_start (frame_start),
    .armed_nxt   (armed_nxt)
  );

  always_comb begin
    evt.line_s     = line_start;
    evt.field_s    = field_start;
    evt.frame_s    = frame_start;
    evt.tri_s      = tri_sync;
    evt.fetch_q    = fetch_win & armed_nxt;
    evt.swap_frame = armed_nxt;
  end

  evt_mux u_mux (
    .sel (sel),
    .evt (evt),
    .src (src)
  );

  always_ff @(posedge clk) begin
    if (rst) aux_out <= 1'b0;
    else     aux_out <= src;
  end
endmodule

// File: rtl/raster_evt_sel_chk.sv
module raster_evt_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] sel,
  input logic       line_start,
  input logic       field_start,
  input logic       frame_start,
  input logic       tri_sync,
  input logic       fetch_win,
  input logic       aux_out
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic pv1, pv2;
  assign pv1 = age >= 2'd1;
  assign pv2 = age >= 2'd2;

  // R1
  rst_low_chk: assert property (@(posedge clk) rst |=> !aux_out);

  // R2
  line_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (pv1 && $past(sel) == 3'd1) |-> aux_out == $past(line_start));

  // R2
  field_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (pv1 && $past(sel) == 3'd2) |-> aux_out == $past(field_start));

  // R2
  frame_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (pv1 && $past(sel) == 3'd3) |-> aux_out == $past(frame_start));

  // R2
  tri_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (pv1 && $past(sel) == 3'd4) |-> aux_out == $past(tri_sync));

  // R3
  const_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pv1 && $past(sel) == 3'd6) |-> aux_out);

  // R3
  const_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pv1 && $past(sel) == 3'd7) |-> !aux_out);

  // R7
  fetch_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pv1 && $past(sel) == 3'd5 && aux_out) |-> $past(fetch_win));

  // R5
  swap_move_chk: assert property (@(posedge clk) disable iff (rst)
    (pv2 && $past(sel) == 3'd0 && $past(sel, 2) == 3'd0 && aux_out != $past(aux_out))
      |-> $past(frame_start));
endmodule

bind raster_evt_sel raster_evt_sel_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .sel         (sel),
  .line_start  (line_start),
  .field_start (field_start),
  .frame_start (frame_start),
  .tri_sync    (tri_sync),
  .fetch_win   (fetch_win),
  .aux_out     (aux_out)
);

// File: tb/test_raster_evt_sel.sv
`timescale 1ns/1ps
module test_raster_evt_sel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = 3'd0;
  logic       line_start = 0, field_start = 0, frame_start = 0;
  logic       tri_sync = 0, fetch_win = 0, swap_req = 0;
  logic       aux_out;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit m_pend = 0;
  bit m_armed = 0;
  bit m_exp = 0;

  always #5 clk = ~clk;

  raster_evt_sel i_raster_evt_sel (
    .clk(clk), .rst(rst), .sel(sel),
    .line_start(line_start), .field_start(field_start),
    .frame_start(frame_start), .tri_sync(tri_sync),
    .fetch_win(fetch_win), .swap_req(swap_req),
    .aux_out(aux_out)
  );

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd0: return "R5";
      3'd1, 3'd2, 3'd3, 3'd4: return "R2";
      3'd5: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string tag, input bit exp);
    checks++;
    if (aux_out !== exp) begin
      errors++;
      $display("FAIL %s t=%0t aux_out=%b expected=%b sel=%0d", tag, $time, aux_out, exp, sel);
    end
  endtask

  // one clock: apply inputs, update model at the edge, compare after it
  task automatic step(input bit ls, input bit fis, input bit frs, input bit ts,
                      input bit fw, input bit sw, input string tag);
    bit nxt;
    line_start = ls; field_start = fis; frame_start = frs;
    tri_sync = ts; fetch_win = fw; swap_req = sw;
    @(posedge clk);
    if (rst) begin
      m_pend = 0; m_armed = 0; m_exp = 0;
    end else begin
      nxt = frs ? (m_pend | sw) : m_armed;
      m_pend = frs ? 1'b0 : (m_pend | sw);
      m_armed = nxt;
      case (sel)
        3'd0: m_exp = m_armed;
        3'd1: m_exp = ls;
        3'd2: m_exp = fis;
        3'd3: m_exp = frs;
        3'd4: m_exp = ts;
        3'd5: m_exp = fw & m_armed;
        3'd6: m_exp = 1'b1;
        default: m_exp = 1'b0;
      endcase
    end
    @(negedge clk);
    check(tag.len() != 0 ? tag : tag_of(sel), m_exp);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic run_traffic(input int n);
    bit fw = 0;
    for (int c = 0; c < n; c++) begin
      if ($urandom_range(0, 7) == 0) fw = ~fw;
      step((c % 13) == 0, (c % 47) == 5, (c % 94) == 5,
           $urandom_range(0, 5) == 0, fw, $urandom_range(0, 60) == 0, "");
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1;
    step(1, 1, 1, 1, 1, 1, "R1");
    step(1, 1, 1, 1, 1, 1, "R1");
    rst = 0;
    idle(3, "R1");

    // R4 / R5: request, then frame start arms exactly one frame
    sel = 3'd0;
    step(0, 0, 0, 0, 0, 1, "R4");
    idle(4, "R4");
    step(0, 0, 1, 0, 0, 0, "R5");
    idle(10, "R5");
    step(0, 0, 1, 0, 0, 0, "R5");
    idle(5, "R5");

    // R6: request coinciding with frame start
    step(0, 0, 1, 0, 0, 1, "R6");
    idle(6, "R6");
    step(0, 0, 1, 0, 0, 0, "R6");
    idle(3, "R6");

    // R8: several requests collapse to one armed frame
    step(0, 0, 0, 0, 0, 1, "R8");
    idle(2, "R8");
    step(0, 0, 0, 0, 0, 1, "R8");
    step(0, 0, 1, 0, 0, 0, "R8");
    idle(4, "R8");
    step(0, 0, 1, 0, 0, 0, "R8");
    idle(4, "R8");
    step(0, 0, 1, 0, 0, 0, "R8");
    idle(2, "R8");

    // R9: request made under code 1, seen later under code 0
    sel = 3'd1;
    step(1, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 1, 0, 0, 0, "R9");
    idle(2, "R9");
    sel = 3'd0;
    idle(4, "R9");

    // R7: qualified window over an armed frame
    sel = 3'd5;
    step(0, 0, 0, 0, 1, 1, "R7");
    step(0, 0, 1, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 1, 0, 1, 0, "R7");

    // every code under mixed traffic
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      run_traffic(400);
    end

    // R1: reset in the middle of an armed frame
    sel = 3'd0;
    step(0, 0, 0, 0, 0, 1, "R1");
    step(0, 0, 1, 0, 0, 0, "R1");
    rst = 1;
    step(0, 0, 0, 0, 0, 0, "R1");
    rst = 0;
    idle(3, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule